// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a single-word host request port and a four-bank SDRAM with a 32-bit data bus. After reset it brings the memory up in a fixed order. It waits for the supply to settle, precharges every bank, issues a run of auto-refresh cycles and then writes the mode register. After that it turns each host request into the SDRAM commands that request needs. It keeps one open row per bank, so a second access to an open row goes straight to the column command. An access to a different row in an open bank first closes that row. An access to a closed bank opens it first.

A refresh timer raises a request about every 15.6 us, which gives 4096 refreshes in each 64 ms window. The request is served at the next idle point. Any open banks are closed first. The CAS latency (2 or 3) and the burst type are taken from two configuration pins when the mode register is written. The burst length is fixed at one word, and writes use the single-location write mode. Read data is captured from the memory bus exactly CAS-latency clocks after the READ command is sampled, and is returned with a one-cycle valid strobe.

The request port is valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The host must hold the address, data and byte enables steady while `req_valid` is high and `req_ready` is low. The response port has no ready signal and cannot apply back-pressure. The host must take `rsp_data` in the cycle where `rsp_valid` is high. Read responses come back in the order the reads were accepted.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is held, the command pins encode NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), and `req_ready`, `init_done` and `rsp_valid` are all low.
- R2: The first command after reset is a precharge-all (address bit 10 high), issued no earlier than T_INIT cycles after reset is released. It is followed by at least INIT_REFS auto-refresh commands, each spaced at least T_RFC apart and at least T_RP after the precharge. Only then is the mode register written, and `init_done` rises.
- R3: The mode register key on the address bus is as follows. Bits 2:0 are 000 (one-word burst). Bit 3 equals `cfg_interleave`. Bits 6:4 hold the CAS latency (010 or 011, chosen by `cfg_cas3`). Bit 9 is 1 (single-location writes). All other bits and the bank address are 0.
- R4: `req_ready` is high only after initialisation, in an idle cycle with no refresh pending. It drops in the cycle after a request is taken.
- R5: The request address is split as follows: bits 20:19 are the bank, bits 18:7 are the row and bits 6:0 are the column. An access to a closed bank issues exactly one ACTIVE for that bank and row, then the column command at least T_RCD cycles later, with no precharge.
- R6: An access to the row that is already open in its bank issues the column command with no ACTIVE and no PRECHARGE.
- R7: An access to a different row in an open bank first precharges that bank alone (address bit 10 low). It then issues ACTIVE at least T_RP cycles after the precharge.
- R8: A WRITE carries the write data with the data-output enable high. In the same cycle the mask lines are the inverse of `req_be`, so lanes whose enable bit is 0 keep their old contents. Column commands never request auto-precharge (address bit 10 low).
- R9: Read data is the bus value sampled CAS-latency clocks after the READ command is sampled. It appears on `rsp_data` with `rsp_valid` high for one cycle. Reads return in request order.
- R10: Auto-refresh is issued about once every REF_INTERVAL cycles. Any open bank is precharged before the refresh. No command follows a refresh for T_RFC cycles. After a refresh, every row is closed, so the next access to a previously open row activates it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all SDRAM pins change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas3 | input | 1 | 1 selects CAS latency 3, 0 selects 2; taken when the mode register is written |
| cfg_interleave | input | 1 | Burst type written into the mode register |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 21 | Bank, row and column word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for a write |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_data | output | 32 | Read data |
| init_done | output | 1 | Power-up sequence complete |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 12 | SDRAM row, column or mode key |
| sd_dqm | output | 4 | Per-byte data mask |
| sd_dq_out | output | 32 | Data driven to the memory |
| sd_dq_oe | output | 1 | Enable for `sd_dq_out` |
| sd_dq_in | input | 32 | Data returned by the memory |

## Verification
The hardest case to reach from the ports is a refresh that arrives while banks hold open rows. Close behind it is a row hit or row conflict whose command counts are not disturbed by a refresh landing in the middle. The stimulus therefore waits until it sees a refresh on the command pins. It then runs each hit, miss or conflict sequence inside the quiet window that follows, and counts ACTIVE and PRECHARGE commands seen by a memory model in the bench. A separate step leaves a bank open and waits for the next refresh. The whole sequence runs twice from reset, once with CAS latency 3 and sequential bursts and once with latency 2 and interleaved bursts, so that read capture is checked at both latencies.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IREF,
    ST_MRS,
    ST_IDLE,
    ST_REF,
    ST_ACT,
    ST_COL
  } ctl_state_e;

endpackage

// File: rtl/sdc_ref_timer.sv
module sdc_ref_timer #(
  parameter int REF_INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pend
);
  localparam int CW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= CW'(REF_INTERVAL - 1);
      pend <= 1'b0;
    end else begin
      if (en) cnt <= tick ? CW'(REF_INTERVAL - 1) : cnt - 1'b1;
      if (tick) pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end

  // a new interval must not expire while the previous refresh is still owed
  p_no_lost_refresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend) |-> ack)
    else $error("refresh interval expired with a refresh still pending");

endmodule

// File: rtl/sdc_bank_table.sv
module sdc_bank_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  input  logic              act_en,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [ROW_W-1:0]  act_row,
  input  logic              pre_one,
  input  logic [BANK_W-1:0] pre_bank,
  input  logic              pre_all,
  output logic              hit,
  output logic              open_sel,
  output logic              any_open,
  output logic [(1<<BANK_W)-1:0] open_vec
);
  localparam int NBANK = 1 << BANK_W;

  logic [NBANK-1:0] hit_vec;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             v;
    logic [ROW_W-1:0] r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v <= 1'b0;
        r <= '0;
      end else if (pre_all || (pre_one && pre_bank == BANK_W'(b))) begin
        v <= 1'b0;
      end else if (act_en && act_bank == BANK_W'(b)) begin
        v <= 1'b1;
        r <= act_row;
      end
    end

    assign open_vec[b] = v;
    assign hit_vec[b]  = v && (r == look_row);
  end

  assign hit      = hit_vec[look_bank];
  assign open_sel = open_vec[look_bank];
  assign any_open = |open_vec;

  p_act_closed_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |-> !open_vec[act_bank])
    else $error("activate issued to a bank that already has an open row");

  p_pre_open_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_one |-> open_vec[pre_bank])
    else $error("single-bank precharge aimed at a closed bank");

endmodule

// File: rtl/sdc_rd_capture.sv
module sdc_rd_capture #(
  parameter int DATA_W = 32,
  parameter int MAX_CL = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(MAX_CL+1)-1:0] cl_val,
  input  logic                        launch,
  input  logic [DATA_W-1:0]           dq_in,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data
);
  logic [MAX_CL:0] pipe;
  logic            take;

  assign take = pipe[cl_val];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      pipe      <= {pipe[MAX_CL-1:0], launch};
      rsp_valid <= take;
      if (take) rsp_data <= dq_in;
    end
  end

  p_one_read_in_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pipe) <= 1)
    else $error("two reads overlap on the data bus");

  p_rsp_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("response strobe held longer than one cycle");

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdc_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 7,
  parameter int BANK_W       = 2,
  parameter int DATA_W       = 32,
  parameter int T_INIT       = 20000,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 3,
  parameter int T_RFC        = 9,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 2,
  parameter int INIT_REFS    = 2,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_cas3,
  input  logic                          cfg_interleave,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [DATA_W/8-1:0]           req_be,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          init_done,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DATA_W/8-1:0]           sd_dqm,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in
);
  localparam int AW    = BANK_W + ROW_W + COL_W;
  localparam int BE_W  = DATA_W / 8;
  localparam int NBANK = 1 << BANK_W;
  localparam int WC_W  = $clog2(T_INIT + T_RFC + T_RP + T_RCD + T_WR + 8);
  localparam int RC_W  = $clog2(INIT_REFS + 1);
  localparam int MAX_CL = 3;
  localparam int CLV_W = $clog2(MAX_CL + 1);

  // request address split
  logic [BANK_W-1:0] rq_bank;
  logic [ROW_W-1:0]  rq_row;
  logic [COL_W-1:0]  rq_col;
  assign rq_bank = req_addr[AW-1 -: BANK_W];
  assign rq_row  = req_addr[COL_W +: ROW_W];
  assign rq_col  = req_addr[COL_W-1:0];

  // state
  ctl_state_e        st, st_d;
  logic [WC_W-1:0]   wcnt, wcnt_d;
  logic [RC_W-1:0]   refs, refs_d;
  logic              done_d;
  logic              cl3_q;
  sd_cmd_e           cmd_q, cmd_d;
  logic [ROW_W-1:0]  addr_d;
  logic [BANK_W-1:0] ba_d;
  logic [BE_W-1:0]   dqm_d;
  logic [DATA_W-1:0] dq_d;
  logic              oe_d;

  // latched request
  logic              lat_write;
  logic [BANK_W-1:0] lat_bank;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;
  logic [DATA_W-1:0] lat_wdata;
  logic [BE_W-1:0]   lat_be;

  // control pulses
  logic accept, act_en, pre_one, pre_all, ref_ack, launch;
  logic hit, open_sel, any_open, ref_pend;
  logic [NBANK-1:0] open_vec;
  logic [ROW_W-1:0] mode_key;

  always_comb begin
    mode_key      = '0;
    mode_key[2:0] = 3'b000;
    mode_key[3]   = cfg_interleave;
    mode_key[6:4] = cfg_cas3 ? 3'b011 : 3'b010;
    mode_key[9]   = 1'b1;
  end

  assign req_ready = (st == ST_IDLE) && (wcnt == '0) && !ref_pend;

  always_comb begin
    st_d    = st;
    wcnt_d  = wcnt;
    refs_d  = refs;
    done_d  = init_done;
    cmd_d   = CMD_NOP;
    addr_d  = '0;
    ba_d    = '0;
    dqm_d   = '0;
    dq_d    = '0;
    oe_d    = 1'b0;
    accept  = 1'b0;
    act_en  = 1'b0;
    pre_one = 1'b0;
    pre_all = 1'b0;
    ref_ack = 1'b0;
    launch  = 1'b0;
    if (wcnt != '0) begin
      wcnt_d = wcnt - 1'b1;
    end else begin
      case (st)
        ST_PWR: begin
          cmd_d      = CMD_PRE;
          addr_d[10] = 1'b1;
          wcnt_d     = WC_W'(T_RP - 1);
          refs_d     = RC_W'(INIT_REFS);
          st_d       = ST_IREF;
        end
        ST_IREF: begin
          cmd_d  = CMD_REF;
          wcnt_d = WC_W'(T_RFC - 1);
          refs_d = refs - 1'b1;
          if (refs == RC_W'(1)) st_d = ST_MRS;
        end
        ST_MRS: begin
          cmd_d  = CMD_MRS;
          addr_d = mode_key;
          wcnt_d = WC_W'(T_MRD - 1);
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            if (any_open) begin
              cmd_d      = CMD_PRE;
              addr_d[10] = 1'b1;
              pre_all    = 1'b1;
              wcnt_d     = WC_W'(T_RP - 1);
            end
            st_d = ST_REF;
          end else if (req_valid) begin
            accept = 1'b1;
            if (hit) begin
              st_d = ST_COL;
            end else if (open_sel) begin
              cmd_d   = CMD_PRE;
              ba_d    = rq_bank;
              pre_one = 1'b1;
              wcnt_d  = WC_W'(T_RP - 1);
              st_d    = ST_ACT;
            end else begin
              st_d = ST_ACT;
            end
          end
        end
        ST_REF: begin
          cmd_d   = CMD_REF;
          ref_ack = 1'b1;
          wcnt_d  = WC_W'(T_RFC - 1);
          st_d    = ST_IDLE;
        end
        ST_ACT: begin
          cmd_d  = CMD_ACT;
          ba_d   = lat_bank;
          addr_d = lat_row;
          act_en = 1'b1;
          wcnt_d = WC_W'(T_RCD - 1);
          st_d   = ST_COL;
        end
        ST_COL: begin
          ba_d   = lat_bank;
          addr_d = ROW_W'(lat_col);
          if (lat_write) begin
            cmd_d  = CMD_WR;
            oe_d   = 1'b1;
            dq_d   = lat_wdata;
            dqm_d  = ~lat_be;
            wcnt_d = WC_W'(T_WR - 1);
          end else begin
            cmd_d  = CMD_RD;
            launch = 1'b1;
            // keep the bus quiet until the read data has passed
            wcnt_d = cl3_q ? WC_W'(4) : WC_W'(3);
          end
          st_d = ST_IDLE;
        end
        default: st_d = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_PWR;
      wcnt      <= WC_W'(T_INIT);
      refs      <= '0;
      init_done <= 1'b0;
      cl3_q     <= 1'b1;
      cmd_q     <= CMD_NOP;
      sd_addr   <= '0;
      sd_ba     <= '0;
      sd_dqm    <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      lat_write <= 1'b0;
      lat_bank  <= '0;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_wdata <= '0;
      lat_be    <= '0;
    end else begin
      st        <= st_d;
      wcnt      <= wcnt_d;
      refs      <= refs_d;
      init_done <= done_d;
      cmd_q     <= cmd_d;
      sd_addr   <= addr_d;
      sd_ba     <= ba_d;
      sd_dqm    <= dqm_d;
      sd_dq_out <= dq_d;
      sd_dq_oe  <= oe_d;
      if (cmd_d == CMD_MRS) cl3_q <= cfg_cas3;
      if (accept) begin
        lat_write <= req_write;
        lat_bank  <= rq_bank;
        lat_row   <= rq_row;
        lat_col   <= rq_col;
        lat_wdata <= req_wdata;
        lat_be    <= req_be;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  sdc_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_bank(rq_bank),
    .look_row (rq_row),
    .act_en   (act_en),
    .act_bank (lat_bank),
    .act_row  (lat_row),
    .pre_one  (pre_one),
    .pre_bank (rq_bank),
    .pre_all  (pre_all),
    .hit      (hit),
    .open_sel (open_sel),
    .any_open (any_open),
    .open_vec (open_vec)
  );

  sdc_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_ref (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (init_done),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  sdc_rd_capture #(.DATA_W(DATA_W), .MAX_CL(MAX_CL)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cl_val   (cl3_q ? CLV_W'(3) : CLV_W'(2)),
    .launch   (launch),
    .dq_in    (sd_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  p_ready_after_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done)
    else $error("request accepted before initialisation finished");

  p_column_to_open_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> open_vec[sd_ba])
    else $error("column command to a bank with no open row");

  p_refresh_banks_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> !any_open)
    else $error("refresh issued while a bank is open");

  p_mask_only_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_dqm != '0) |-> (cmd_q == CMD_WR))
    else $error("byte mask active outside a write");

endmodule

// File: tb/sdram_seq_ctrl_tb.sv
module sdram_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_INIT = 20, T_RP = 3, T_RCD = 3, T_RFC = 9, T_MRD = 2, T_WR = 2;
  localparam int INIT_REFS = 2, REF_INTERVAL = 300;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, cfg_cas3 = 1'b1, cfg_interleave = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready, rsp_valid, init_done;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_data, sd_dq_out, sd_dq_in;
  logic [3:0]  req_be = '0, sd_dqm;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;

  sdram_seq_ctrl #(.T_INIT(T_INIT), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_WR(T_WR), .INIT_REFS(INIT_REFS), .REF_INTERVAL(REF_INTERVAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3), .cfg_interleave(cfg_interleave),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .init_done(init_done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  int cyc = 0, rst_rel = 0, last_ref = -1000, last_mrs = -1000, ml_cl = 3;
  int last_pre[4], last_act[4], orow[4];
  bit mopen[4];
  int n_act = 0, n_pre = 0, n_ref = 0, ref_at_rst = 0;
  int last_ba = 0, last_row = 0, last_col = 0, key = 0;
  bit saw_cmd = 0, exp_cl3 = 1, exp_il = 0;
  logic [3:0]  cmd;
  logic [31:0] mem [int];
  logic [31:0] cur, mkey;
  bit          pv[4];
  logic [31:0] pd[4];

  assign sd_dq_in = pv[0] ? pd[0] : 32'hBAD0_BAD0;

  always @(posedge clk) begin
    cyc++;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst_n) begin
      rst_rel = cyc; saw_cmd = 0; last_ref = -1000; last_mrs = -1000; ref_at_rst = n_ref;
      for (int i = 0; i < 4; i++) begin
        mopen[i] = 0; last_pre[i] = -1000; last_act[i] = -1000; pv[i] <= 0;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin pv[i] <= pv[i+1]; pd[i] <= pd[i+1]; end
      pv[3] <= 0;
      if (cmd != 4'b0111 && cmd[3] == 1'b0) begin
        if (!saw_cmd) begin
          saw_cmd = 1;
          chk(cmd == 4'b0010 && sd_addr[10], "R2 first command is precharge-all", cmd, 4'b0010);
          chk(cyc - rst_rel >= T_INIT, "R2 power-up wait", cyc - rst_rel, T_INIT);
        end
        chk(cyc - last_mrs >= T_MRD, "R2 mode-set recovery", cyc - last_mrs, T_MRD);
        chk(cyc - last_ref >= T_RFC, "R10 refresh recovery", cyc - last_ref, T_RFC);
        case (cmd)
          4'b0010: begin
            n_pre++;
            for (int i = 0; i < 4; i++)
              if (sd_addr[10] || sd_ba == i[1:0]) begin mopen[i] = 0; last_pre[i] = cyc; end
          end
          4'b0011: begin
            chk(!mopen[sd_ba], "R5 activate on closed bank", mopen[sd_ba], 0);
            chk(cyc - last_pre[sd_ba] >= T_RP, "R7 precharge to activate", cyc - last_pre[sd_ba], T_RP);
            mopen[sd_ba] = 1; orow[sd_ba] = sd_addr; last_act[sd_ba] = cyc;
            last_ba = sd_ba; last_row = sd_addr; n_act++;
          end
          4'b0101, 4'b0100: begin
            chk(mopen[sd_ba], "R5 column command to open bank", mopen[sd_ba], 1);
            chk(cyc - last_act[sd_ba] >= T_RCD, "R5 activate to column", cyc - last_act[sd_ba], T_RCD);
            chk(sd_addr[10] == 1'b0, "R8 no auto-precharge", sd_addr[10], 0);
            key = (int'(sd_ba) << 19) | (orow[sd_ba] << 7) | int'(sd_addr[6:0]);
            last_col = sd_addr[6:0];
            if (cmd == 4'b0100) begin
              chk(sd_dq_oe, "R8 data driven with write", sd_dq_oe, 1);
              cur = mem.exists(key) ? mem[key] : 32'h0;
              for (int b = 0; b < 4; b++) if (!sd_dqm[b]) cur[b*8 +: 8] = sd_dq_out[b*8 +: 8];
              mem[key] = cur;
            end else begin
              pv[ml_cl-1] <= 1;
              pd[ml_cl-1] <= mem.exists(key) ? mem[key] : 32'h0;
            end
          end
          4'b0001: begin
            chk(!(mopen[0] | mopen[1] | mopen[2] | mopen[3]), "R10 banks closed at refresh",
                {mopen[3], mopen[2], mopen[1], mopen[0]}, 0);
            for (int i = 0; i < 4; i++)
              chk(cyc - last_pre[i] >= T_RP, "R2 precharge to refresh", cyc - last_pre[i], T_RP);
            n_ref++; last_ref = cyc;
          end
          4'b0000: begin
            mkey = 32'h200 | ((exp_cl3 ? 3 : 2) << 4) | (32'(exp_il) << 3);
            chk(sd_addr == mkey[11:0] && sd_ba == 2'b00, "R3 mode register key", sd_addr, mkey);
            chk(n_ref - ref_at_rst >= INIT_REFS, "R2 refreshes before mode set", n_ref - ref_at_rst, INIT_REFS);
            ml_cl = int'(sd_addr[6:4]); last_mrs = cyc;
          end
          default: chk(0, "R2 unknown command", cmd, 0);
        endcase
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [31:0] expq[$];
  logic [31:0] shadow [int];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk(0, "R9 unexpected response", rsp_data, 0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(rsp_data == e, "R9 read data after CAS latency", rsp_data, e);
      end
    end
  end

  task automatic send(input bit wr, input int ba, input int row, input int col,
                      input logic [31:0] d, input logic [3:0] be);
    int k;
    logic [31:0] c;
    k = (ba << 19) | (row << 7) | col;
    req_write = wr; req_addr = {ba[1:0], row[11:0], col[6:0]};
    req_wdata = d; req_be = be; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R4 ready drops after accept", req_ready, 0);
    if (wr) begin
      c = shadow.exists(k) ? shadow[k] : 32'h0;
      for (int b = 0; b < 4; b++) if (be[b]) c[b*8 +: 8] = d[b*8 +: 8];
      shadow[k] = c;
    end else expq.push_back(shadow.exists(k) ? shadow[k] : 32'h0);
  endtask

  task automatic settle();
    repeat (15) @(negedge clk);
    chk(expq.size() == 0, "R9 all reads answered", expq.size(), 0);
  endtask

  task automatic sync_ref();
    int r;
    r = n_ref;
    while (n_ref == r) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic run_phase(input bit cl3, input bit il, input logic [31:0] salt);
    int a0, p0, r0;
    exp_cl3 = cl3; exp_il = il; cfg_cas3 = cl3; cfg_interleave = il;
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(!req_ready && !init_done && !rsp_valid, "R1 outputs low in reset",
        {req_ready, init_done, rsp_valid}, 0);
    rst_n = 1'b1;
    while (!init_done) @(negedge clk);

    sync_ref();
    a0 = n_act; p0 = n_pre;
    send(1, 0, 3, 5, 32'h1111_2222 ^ salt, 4'hF); settle();
    chk(n_act - a0 == 1 && n_pre == p0, "R5 closed bank: one activate, no precharge",
        {n_act - a0, n_pre - p0}, 64'h1_0000_0000);
    a0 = n_act; p0 = n_pre;
    send(0, 0, 3, 5, 0, 0); settle();
    chk(n_act == a0 && n_pre == p0, "R6 row hit without activate or precharge",
        {n_act - a0, n_pre - p0}, 0);
    send(1, 0, 3, 5, 32'hAABB_CCDD ^ salt, 4'b0101);
    send(0, 0, 3, 5, 0, 0); settle();

    sync_ref();
    send(0, 0, 3, 5, 0, 0); settle();
    a0 = n_act; p0 = n_pre;
    send(1, 0, 7, 9, 32'h5566_7788 ^ salt, 4'hF); settle();
    chk(n_act - a0 == 1 && n_pre - p0 == 1, "R7 conflict: precharge then activate",
        {n_act - a0, n_pre - p0}, 64'h1_0000_0001);
    send(0, 0, 3, 5, 0, 0);
    send(0, 0, 7, 9, 0, 0); settle();

    send(1, 2, 9, 127, 32'hCAFE_0000 ^ salt, 4'hF); settle();
    chk(last_ba == 2 && last_row == 9 && last_col == 127, "R5 address split",
        {last_ba[7:0], last_row[15:0], last_col[7:0]}, {8'd2, 16'd9, 8'd127});
    send(0, 2, 9, 127, 0, 0); settle();

    send(1, 1, 20, 0, 32'h0BAD_F00D ^ salt, 4'b1110); settle();
    r0 = n_ref; p0 = n_pre;
    while (n_ref == r0) @(negedge clk);
    chk(n_pre - p0 >= 1, "R10 precharge-all before refresh", n_pre - p0, 1);
    repeat (12) @(negedge clk);
    a0 = n_act;
    send(0, 1, 20, 0, 0, 0); settle();
    chk(n_act - a0 == 1, "R10 row reopened after refresh", n_act - a0, 1);

    r0 = n_ref;
    repeat (3 * REF_INTERVAL) @(negedge clk);
    chk(n_ref - r0 >= 2 && n_ref - r0 <= 4, "R10 refresh rate", n_ref - r0, 3);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      chk(0, "watchdog expired", wd, 150000);
      report();
    end
  end

  initial begin
    @(negedge clk);
    run_phase(1'b1, 1'b0, 32'h0);
    run_phase(1'b0, 1'b1, 32'h0F0F_0F0F);
    report();
  end

endmodule